// File: doc/BRIEF.md
# Tiled DRAM Burst Address Sequencer

This block produces the DRAM burst commands for one pass of a row-column two-dimensional transform over a square dataset of `N_DIM` by `N_DIM` complex elements. The dataset lives off-chip as square tiles of `K_DIM` by `K_DIM` elements. Each tile sits contiguously in exactly one DRAM row, so one burst of `K_DIM*K_DIM` elements drains a whole open row buffer. No element-level stride is ever issued. The same tile layout serves both passes, and only the order in which tiles are visited changes.

A pass begins with a one-cycle `start` pulse. The pulse captures the pass direction and two base row addresses, one for the region being read and one for the region being written, so a pass can move its results into a second DRAM region. For every tile the block emits a read command and then a write command for the same tile coordinates. Tile (tr, tc) maps to row `base + tr*(N_DIM/K_DIM) + tc`. In a row pass the tiles advance along each band of tile-rows, with tc moving fastest. In a column pass they advance down each band of tile-columns, with tr moving fastest. After the final write is accepted, the block pulses `done` and returns to idle.

Commands leave on a valid/ready stream. Once `cmd_valid` is high, it and the command fields stay frozen until a cycle in which `cmd_ready` is also high. That cycle transfers the command. The next command, if any, appears in the following cycle. A downstream controller may hold `cmd_ready` low for any number of cycles.

Top module: `tiled_dram_addr_gen`

## Requirements
- R1: After reset, `cmd_valid` and `done` are both low, and they stay low until `start` is pulsed.
- R2: With `col_pass`=0 captured, tiles are visited with tc incrementing fastest from 0 to N_DIM/K_DIM-1 and then tr incrementing, starting at tile (0,0).
- R3: With `col_pass`=1 captured, tiles are visited with tr incrementing fastest and then tc, starting at tile (0,0).
- R4: The row address of a command is `base + tr*(N_DIM/K_DIM) + tc`, modulo 2^ADDR_W. Read commands use the captured `rd_base` and write commands use the captured `wr_base`.
- R5: Each tile yields exactly two commands: a read (`cmd_write`=0) followed by a write (`cmd_write`=1) for the same tile.
- R6: `cmd_len` equals K_DIM*K_DIM on every valid command.
- R7: While `cmd_valid` is high and `cmd_ready` is low, `cmd_row`, `cmd_write` and `cmd_len` keep their values into the next cycle.
- R8: `done` is high for exactly the one cycle after the handshake of the 2*(N_DIM/K_DIM)^2-th command of a pass, and `cmd_valid` is low in that cycle.
- R9: A `start` pulse while a pass is in progress has no effect. Changes to `col_pass`, `rd_base` or `wr_base` after capture have no effect on the current pass.
- R10: `cmd_valid` never falls without a handshake, and the first command appears in the cycle after `start` is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin a pass; taken only while idle |
| col_pass | input | 1 | Pass direction captured at start: 0 row pass, 1 column pass |
| rd_base | input | ADDR_W | Row address of tile (0,0) in the source region |
| wr_base | input | ADDR_W | Row address of tile (0,0) in the destination region |
| cmd_valid | output | 1 | A command is offered |
| cmd_ready | input | 1 | Downstream accepts the offered command |
| cmd_row | output | ADDR_W | DRAM row address of the burst |
| cmd_len | output | LEN_W | Burst length in elements, K_DIM*K_DIM |
| cmd_write | output | 1 | 0 for a read burst, 1 for a write burst |
| done | output | 1 | One-cycle pulse when a pass has finished |

## Verification
The assertions assume that the reset is held for at least one clock and that `cmd_ready` is a plain level with no dependence on later cycles. They also assume that the stream rules are judged only in cycles after reset is released. The stimulus drives every input on the falling edge. It varies `cmd_ready` from an LFSR in some passes and holds it high in others, so both long stalls and back-to-back transfers occur. It also deliberately pulses `start` and alters the bases and direction in the middle of a pass, so the captured values must carry the pass. The reference model in the bench rebuilds the full command list from the requirements at each accepted start and pops one entry per handshake.

// File: rtl/tdag_pkg.sv
package tdag_pkg;

  typedef enum logic {
    PH_RD = 1'b0,
    PH_WR = 1'b1
  } phase_e;

endpackage

// File: rtl/tdag_tile_walker.sv
module tdag_tile_walker #(
  parameter int TILES = 8,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             col_mode,
  input  logic             adv,
  output logic [CNT_W-1:0] tr,
  output logic [CNT_W-1:0] tc,
  output logic             last
);

  localparam logic [CNT_W-1:0] TOP = CNT_W'(TILES - 1);

  logic [CNT_W-1:0] fast_q, slow_q;
  logic             fast_wrap;

  assign fast_wrap = (fast_q == TOP);

  always_ff @(posedge clk) begin
    if (!rst_n || load) begin
      fast_q <= '0;
      slow_q <= '0;
    end else if (adv) begin
      if (fast_wrap) begin
        fast_q <= '0;
        slow_q <= slow_q + 1'b1;
      end else begin
        fast_q <= fast_q + 1'b1;
      end
    end
  end

  // The fast counter runs along tc in a row pass and along tr in a column pass.
  always_comb begin
    if (col_mode) begin
      tr = fast_q;
      tc = slow_q;
    end else begin
      tr = slow_q;
      tc = fast_q;
    end
  end

  assign last = fast_wrap && (slow_q == TOP);

endmodule

// File: rtl/tdag_addr_map.sv
module tdag_addr_map
  import tdag_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 3
) (
  input  logic [ADDR_W-1:0] rd_base,
  input  logic [ADDR_W-1:0] wr_base,
  input  phase_e            phase,
  input  logic [CNT_W-1:0]  tr,
  input  logic [CNT_W-1:0]  tc,
  output logic [ADDR_W-1:0] row
);

  localparam int PAD = ADDR_W - 2 * CNT_W;

  logic [ADDR_W-1:0] offset;

  // tr*TILES + tc is a plain concatenation because TILES is a power of two.
  generate
    if (PAD > 0) begin : g_pad
      assign offset = {{PAD{1'b0}}, tr, tc};
    end else begin : g_nopad
      assign offset = {tr, tc};
    end
  endgenerate

  assign row = ((phase == PH_WR) ? wr_base : rd_base) + offset;

endmodule

// File: rtl/tdag_ctrl.sv
module tdag_ctrl
  import tdag_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              col_pass,
  input  logic [ADDR_W-1:0] rd_base,
  input  logic [ADDR_W-1:0] wr_base,
  input  logic              cmd_ready,
  input  logic              tile_last,
  output logic              busy,
  output phase_e            phase,
  output logic              col_mode,
  output logic [ADDR_W-1:0] rd_base_q,
  output logic [ADDR_W-1:0] wr_base_q,
  output logic              load,
  output logic              tile_adv,
  output logic              done
);

  logic hs;

  assign hs       = busy && cmd_ready;
  assign load     = start && !busy;
  assign tile_adv = hs && (phase == PH_WR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      phase     <= PH_RD;
      col_mode  <= 1'b0;
      rd_base_q <= '0;
      wr_base_q <= '0;
      done      <= 1'b0;
    end else begin
      done <= tile_adv && tile_last;
      if (load) begin
        busy      <= 1'b1;
        phase     <= PH_RD;
        col_mode  <= col_pass;
        rd_base_q <= rd_base;
        wr_base_q <= wr_base;
      end else if (hs) begin
        if (phase == PH_RD) begin
          phase <= PH_WR;
        end else begin
          phase <= PH_RD;
          if (tile_last) busy <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/tiled_dram_addr_gen.sv
module tiled_dram_addr_gen
  import tdag_pkg::*;
#(
  parameter int N_DIM  = 64,
  parameter int K_DIM  = 8,
  parameter int ADDR_W = 24,
  localparam int TILES = N_DIM / K_DIM,
  localparam int CNT_W = $clog2(TILES),
  localparam int BURST = K_DIM * K_DIM,
  localparam int LEN_W = $clog2(BURST) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              col_pass,
  input  logic [ADDR_W-1:0] rd_base,
  input  logic [ADDR_W-1:0] wr_base,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [ADDR_W-1:0] cmd_row,
  output logic [LEN_W-1:0]  cmd_len,
  output logic              cmd_write,
  output logic              done
);

  logic              busy, col_mode, load, tile_adv, tile_last;
  phase_e            phase;
  logic [ADDR_W-1:0] rd_base_q, wr_base_q;
  logic [CNT_W-1:0]  tr, tc;

  tdag_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .col_pass  (col_pass),
    .rd_base   (rd_base),
    .wr_base   (wr_base),
    .cmd_ready (cmd_ready),
    .tile_last (tile_last),
    .busy      (busy),
    .phase     (phase),
    .col_mode  (col_mode),
    .rd_base_q (rd_base_q),
    .wr_base_q (wr_base_q),
    .load      (load),
    .tile_adv  (tile_adv),
    .done      (done)
  );

  tdag_tile_walker #(.TILES(TILES), .CNT_W(CNT_W)) walk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .col_mode (col_mode),
    .adv      (tile_adv),
    .tr       (tr),
    .tc       (tc),
    .last     (tile_last)
  );

  tdag_addr_map #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) map_i (
    .rd_base (rd_base_q),
    .wr_base (wr_base_q),
    .phase   (phase),
    .tr      (tr),
    .tc      (tc),
    .row     (cmd_row)
  );

  assign cmd_valid = busy;
  assign cmd_write = (phase == PH_WR);
  assign cmd_len   = LEN_W'(BURST);

endmodule

// File: rtl/tdag_checker.sv
module tdag_checker #(
  parameter int ADDR_W = 24,
  parameter int LEN_W  = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [ADDR_W-1:0] cmd_row,
  input logic [LEN_W-1:0]  cmd_len,
  input logic              cmd_write,
  input logic              done
);

  assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> ($stable(cmd_row) && $stable(cmd_write) && $stable(cmd_len)));

  assert_valid_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> cmd_valid);

  assert_write_after_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && !cmd_write) |=> (cmd_valid && cmd_write));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cmd_valid);

  assert_done_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(cmd_valid && cmd_ready && cmd_write));

endmodule

bind tiled_dram_addr_gen tdag_checker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_row   (cmd_row),
  .cmd_len   (cmd_len),
  .cmd_write (cmd_write),
  .done      (done)
);

// File: tb/tiled_dram_addr_gen_tb_top.sv
module tiled_dram_addr_gen_tb_top;

  localparam int N_DIM  = 64;
  localparam int K_DIM  = 8;
  localparam int ADDR_W = 24;
  localparam int T      = N_DIM / K_DIM;
  localparam int BURST  = K_DIM * K_DIM;
  localparam int LEN_W  = $clog2(BURST) + 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic              col_pass = 1'b0;
  logic [ADDR_W-1:0] rd_base = '0;
  logic [ADDR_W-1:0] wr_base = '0;
  logic              cmd_ready = 1'b0;
  logic              cmd_valid, cmd_write, done;
  logic [ADDR_W-1:0] cmd_row;
  logic [LEN_W-1:0]  cmd_len;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  tiled_dram_addr_gen #(.N_DIM(N_DIM), .K_DIM(K_DIM), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .col_pass(col_pass),
    .rd_base(rd_base), .wr_base(wr_base), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_row(cmd_row), .cmd_len(cmd_len),
    .cmd_write(cmd_write), .done(done)
  );

  // Reference model state
  longint q_row[$];
  bit     q_wr[$];
  bit     m_busy = 0;
  bit     m_done = 0;
  bit     m_col  = 0;
  bit     m_stall = 0;

  // Ready pattern
  int         rdy_mode = 0;
  logic [7:0] lfsr = 8'hA5;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic build(input bit col, input longint rb, input longint wb);
    longint mask = (longint'(1) << ADDR_W) - 1;
    q_row.delete();
    q_wr.delete();
    for (int s = 0; s < T; s++) begin
      for (int f = 0; f < T; f++) begin
        int r = col ? f : s;
        int c = col ? s : f;
        q_row.push_back((rb + r * T + c) & mask);
        q_wr.push_back(1'b0);
        q_row.push_back((wb + r * T + c) & mask);
        q_wr.push_back(1'b1);
      end
    end
  endtask

  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    cmd_ready <= (rdy_mode == 0) ? 1'b1 : (lfsr[0] & lfsr[2]);
  end

  // Model advances on each rising edge using inputs settled since the falling edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_stall = 0;
      q_row.delete(); q_wr.delete();
    end else begin
      m_done = 0;
      m_stall = m_busy && !cmd_ready;
      if (m_busy) begin
        if (cmd_ready) begin
          void'(q_row.pop_front());
          void'(q_wr.pop_front());
          if (q_row.size() == 0) begin
            m_busy = 0;
            m_done = 1;
          end
        end
      end else if (start) begin
        m_col = col_pass;
        build(col_pass, longint'(rd_base), longint'(wr_base));
        m_busy = 1;
      end
    end
  end

  // Compare every cycle away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(cmd_valid == m_busy, "R10 cmd_valid", cmd_valid, m_busy);
      chk(done == m_done, "R8 done", done, m_done);
      if (m_busy && cmd_valid) begin
        chk(longint'(cmd_row) == q_row[0],
            m_stall ? "R7 held cmd_row" : (m_col ? "R3/R4 cmd_row column pass" : "R2/R4 cmd_row row pass"),
            cmd_row, q_row[0]);
        chk(cmd_write == q_wr[0], "R5 cmd_write", cmd_write, q_wr[0]);
        chk(cmd_len == LEN_W'(BURST), "R6 cmd_len", cmd_len, BURST);
      end
    end
  end

  task automatic pulse_start(input bit col, input logic [ADDR_W-1:0] rb, input logic [ADDR_W-1:0] wb);
    @(negedge clk);
    col_pass = col; rd_base = rb; wr_base = wb; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle;
    @(negedge clk);
    while (m_busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(cmd_valid == 1'b0, "R1 cmd_valid in reset", cmd_valid, 0);
    chk(done == 1'b0, "R1 done in reset", done, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(cmd_valid == 1'b0, "R1 cmd_valid idle after reset", cmd_valid, 0);

    // R2 row pass, stalling ready
    rdy_mode = 1;
    pulse_start(1'b0, 24'h000100, 24'h004000);
    wait_idle();

    // R3 column pass, ready always high (back-to-back)
    rdy_mode = 0;
    pulse_start(1'b1, 24'h010000, 24'h020000);
    wait_idle();

    // R9: restart and input changes during a pass are ignored; R4 wrap of address
    rdy_mode = 1;
    pulse_start(1'b1, 24'hFFFFF0, 24'h000008);
    repeat (10) @(negedge clk);
    start = 1'b1; col_pass = 1'b0; rd_base = 24'h123456; wr_base = 24'h654321;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    chk(cmd_valid == 1'b1, "R9 pass continues after ignored start", cmd_valid, 1);
    wait_idle();

    // Row pass right after another one, with stalls
    pulse_start(1'b0, 24'h000000, 24'h000000);
    wait_idle();
    chk(cmd_valid == 1'b0, "R8 idle after pass", cmd_valid, 0);

    finish_run();
  end

endmodule